// File: doc/BRIEF.md
# Reset Time-out Sequencer

This block decides when a microcontroller core may leave reset. A power-on event starts it, and an undervoltage condition, the external reset pin or a wake from sleep can start it again. It then walks through a chain of optional waits. First comes a power-up delay counted on a free-running timer clock. Next is an oscillator settling count measured on the main oscillator clock. Last is a PLL lock delay, also counted on the timer clock. Which waits run depends on the configuration bits and on the oscillator mode. When the chain is finished, the internal device reset is released.

A brown-out is recognised only when the synchronised undervoltage input stays high for longer than a filter window. The device is then held in reset until the input clears. After that the power-up delay runs again, and it starts over if the undervoltage comes back before it ends. The external reset pin is synchronised and forces reset while it is low. It does not restart a wait that is already running. A wake request in a crystal mode runs only the oscillator settling count, plus the PLL delay when the PLL is enabled. During that wake sequence the block raises a clock-hold output and leaves the device reset low. Three sticky flags record what caused a reset, and a clear strobe resets them.

The states are named as follows:
- Power-on: `ST_POR`, `ST_PWRT`, `ST_OST`, `ST_PLL`.
- Brown-out: `ST_BOR`, `ST_BPWRT`.
- Normal operation: `ST_RUN`.
- Wake: `ST_WOST`, `ST_WPLL`.

The transitions are:
- POR→PWRT when the power-up timer is enabled.
- POR→OST when the timer is disabled and the mode is a crystal mode.
- POR→RUN otherwise.
- PWRT→OST in crystal modes; PWRT→RUN otherwise.
- OST→PLL when the PLL is enabled; OST→RUN otherwise.
- PLL→RUN.
- Any state except BOR → BOR on a filtered trip.
- BOR→BPWRT when undervoltage clears and the timer is enabled; BOR→RUN when it clears and the timer is disabled.
- BPWRT→BOR when undervoltage returns; BPWRT→RUN when the timer expires.
- RUN→WOST on a wake request in a crystal mode.
- WOST→WPLL when the PLL is enabled; WOST→RUN otherwise.
- WPLL→RUN.

Top module: `rst_seq_top`

## Requirements
- R1: While `por_pulse` is high, `dev_rst` is 1, `clk_hold` is 0, `flag_por` is 1, and `flag_bor` and `flag_ext` are 0.
- R2: In mode RC (`osc_mode`=3) with `cfg_pwrt_en`=1, `dev_rst` falls PWRT_CYCLES+1 timer-clock edges after `por_pulse` falls. With `cfg_pwrt_en`=0 it falls on the first edge.
- R3: In the crystal modes (LP=0, XT=1, HS=2), an oscillator settling count of OST_CYCLES `osc_clk` cycles follows the power-up delay, or follows power-on directly when that delay is disabled. The release then takes that count plus a few synchroniser cycles. In RC mode this count is skipped.
- R4: In a crystal mode with `cfg_pll_en`=1, a further PLL_CYCLES timer-clock cycles follow the settling count before release.
- R5: A brown-out trips only when `cfg_bor_en`=1 and the synchronised `uv_in` has been high for more than BOR_FILT consecutive timer cycles. A pulse shorter than BOR_FILT cycles, or any pulse while `cfg_bor_en`=0, leaves `dev_rst` and `flag_bor` unchanged.
- R6: After a trip, `dev_rst` stays 1 while `uv_in` stays high. After `uv_in` falls, the power-up delay runs (no settling count), and `dev_rst` falls about PWRT_CYCLES+3 edges after `uv_in` falls.
- R7: If `uv_in` rises again during the post-brown-out delay, the block returns to brown-out. The full delay is then counted again from the final fall of `uv_in`.
- R8: `mclr_n` low forces `dev_rst` to 1 within three edges and does not restart a running wait. If it is held low past the end of the waits, releasing it drops `dev_rst` within three edges.
- R9: A one-cycle `wake_req` in `ST_RUN` in a crystal mode raises `clk_hold` for the settling count (plus PLL_CYCLES when the PLL is enabled) while `dev_rst` stays 0. In RC mode `wake_req` leaves `clk_hold` at 0.
- R10: `flag_bor` sets on entry to brown-out and `flag_ext` sets while the synchronised pin is low. The flags hold until `flag_clr`, which clears all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tmr_clk | input | 1 | Free-running timer clock; sequencer domain |
| osc_clk | input | 1 | Main oscillator clock; settling counter domain |
| por_pulse | input | 1 | Power-on pulse, active high, asynchronous reset of the block |
| uv_in | input | 1 | Undervoltage comparator output, active high |
| mclr_n | input | 1 | External reset pin, active low, asynchronous |
| cfg_pwrt_en | input | 1 | Enables the power-up delay |
| cfg_bor_en | input | 1 | Enables brown-out detection |
| cfg_pll_en | input | 1 | Enables the PLL lock wait |
| osc_mode | input | 2 | 0 LP, 1 XT, 2 HS, 3 RC |
| wake_req | input | 1 | One-cycle wake-from-sleep request, timer domain |
| flag_clr | input | 1 | Clears the cause flags |
| dev_rst | output | 1 | Internal device reset, active high |
| clk_hold | output | 1 | Holds the core clock during a wake settling sequence |
| flag_por | output | 1 | Last reset included a power-on |
| flag_bor | output | 1 | Last reset included a brown-out |
| flag_ext | output | 1 | Last reset included the external pin |

## Verification
The release delay is measured for every combination of power-up enable, PLL enable and oscillator mode. This separates the skip rules of each stage, since each stage adds its own span to the delay. Undervoltage pulses just below the filter window and well above it separate filtering from tripping. A pulse inside the post-brown-out delay separates re-arming from letting the old count finish. Pin pulses during a wait, and a pin held past the waits, separate "forces reset" from "restarts the sequence". Wake requests in crystal and RC modes separate the clock-hold path from the device-reset path.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [1:0] {
        OSC_LP = 2'd0,
        OSC_XT = 2'd1,
        OSC_HS = 2'd2,
        OSC_RC = 2'd3
    } osc_mode_e;

    typedef enum logic [3:0] {
        ST_POR,
        ST_PWRT,
        ST_OST,
        ST_PLL,
        ST_BOR,
        ST_BPWRT,
        ST_RUN,
        ST_WOST,
        ST_WPLL
    } seq_state_e;

endpackage

// File: rtl/rst_seq_sync.sv
module rst_seq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic arst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) sh <= {STAGES{RST_VAL}};
        else      sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/rst_seq_bor_filt.sv
module rst_seq_bor_filt #(
    parameter int FILT = 8
) (
    input  logic clk,
    input  logic arst,
    input  logic uv_s,
    input  logic en,
    output logic trip
);
    localparam int CW = $clog2(FILT + 1);
    logic [CW-1:0] cnt;

    // Consecutive-cycle counter, saturating at FILT.
    always_ff @(posedge clk or posedge arst) begin
        if (arst)                    cnt <= '0;
        else if (!uv_s)              cnt <= '0;
        else if (cnt != CW'(FILT))   cnt <= cnt + 1'b1;
    end

    assign trip = en && uv_s && (cnt == CW'(FILT));
endmodule

// File: rtl/rst_seq_ost.sv
module rst_seq_ost #(
    parameter int CYCLES = 1024
) (
    input  logic osc_clk,
    input  logic arst,
    input  logic run_req,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    logic          run_s;
    logic [CW-1:0] cnt;

    rst_seq_sync #(.STAGES(2), .RST_VAL(1'b0)) u_run_sync (
        .clk(osc_clk), .arst(arst), .d(run_req), .q(run_s)
    );

    always_ff @(posedge osc_clk or posedge arst) begin
        if (arst) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!run_s) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            if (cnt == CW'(CYCLES - 1)) done <= 1'b1;
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top
    import rst_seq_pkg::*;
#(
    parameter int PWRT_CYCLES = 18000,
    parameter int PLL_CYCLES  = 500,
    parameter int OST_CYCLES  = 1024,
    parameter int BOR_FILT    = 8
) (
    input  logic       tmr_clk,
    input  logic       osc_clk,
    input  logic       por_pulse,
    input  logic       uv_in,
    input  logic       mclr_n,
    input  logic       cfg_pwrt_en,
    input  logic       cfg_bor_en,
    input  logic       cfg_pll_en,
    input  logic [1:0] osc_mode,
    input  logic       wake_req,
    input  logic       flag_clr,
    output logic       dev_rst,
    output logic       clk_hold,
    output logic       flag_por,
    output logic       flag_bor,
    output logic       flag_ext
);
    localparam int TMAX = (PWRT_CYCLES > PLL_CYCLES) ? PWRT_CYCLES : PLL_CYCLES;
    localparam int TW   = $clog2(TMAX + 1);

    seq_state_e    state, nxt;
    logic [TW-1:0] tcnt;
    logic          uv_s, mclr_s, ost_done, ost_done_s, bor_trip, ost_run;
    logic          xtal, pwrt_done, pll_done;
    osc_mode_e     mode;

    assign mode      = osc_mode_e'(osc_mode);
    assign xtal      = (mode != OSC_RC);
    assign pwrt_done = (tcnt == TW'(PWRT_CYCLES - 1));
    assign pll_done  = (tcnt == TW'(PLL_CYCLES - 1));
    assign ost_run   = (state == ST_OST) || (state == ST_WOST);

    rst_seq_sync #(.STAGES(2), .RST_VAL(1'b0)) u_uv_sync (
        .clk(tmr_clk), .arst(por_pulse), .d(uv_in), .q(uv_s)
    );
    rst_seq_sync #(.STAGES(2), .RST_VAL(1'b1)) u_pin_sync (
        .clk(tmr_clk), .arst(por_pulse), .d(mclr_n), .q(mclr_s)
    );
    rst_seq_sync #(.STAGES(2), .RST_VAL(1'b0)) u_done_sync (
        .clk(tmr_clk), .arst(por_pulse), .d(ost_done), .q(ost_done_s)
    );

    rst_seq_bor_filt #(.FILT(BOR_FILT)) u_filt (
        .clk(tmr_clk), .arst(por_pulse), .uv_s(uv_s), .en(cfg_bor_en), .trip(bor_trip)
    );

    rst_seq_ost #(.CYCLES(OST_CYCLES)) u_ost (
        .osc_clk(osc_clk), .arst(por_pulse), .run_req(ost_run), .done(ost_done)
    );

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_POR:   nxt = cfg_pwrt_en ? ST_PWRT : (xtal ? ST_OST : ST_RUN);
            ST_PWRT:  if (pwrt_done) nxt = xtal ? ST_OST : ST_RUN;
            ST_OST:   if (ost_done_s) nxt = cfg_pll_en ? ST_PLL : ST_RUN;
            ST_PLL:   if (pll_done) nxt = ST_RUN;
            ST_BOR:   if (!uv_s) nxt = cfg_pwrt_en ? ST_BPWRT : ST_RUN;
            ST_BPWRT: begin
                if (uv_s && cfg_bor_en) nxt = ST_BOR;
                else if (pwrt_done)     nxt = ST_RUN;
            end
            ST_RUN:   if (wake_req && xtal && !ost_done_s) nxt = ST_WOST;
            ST_WOST:  if (ost_done_s) nxt = cfg_pll_en ? ST_WPLL : ST_RUN;
            ST_WPLL:  if (pll_done) nxt = ST_RUN;
            default:  nxt = ST_POR;
        endcase
        if (bor_trip) nxt = ST_BOR;
    end

    // State register
    always_ff @(posedge tmr_clk or posedge por_pulse) begin
        if (por_pulse) state <= ST_POR;
        else           state <= nxt;
    end

    // Shared timer for power-up and PLL waits; restarts on every state change
    always_ff @(posedge tmr_clk or posedge por_pulse) begin
        if (por_pulse)
            tcnt <= '0;
        else if (nxt != state)
            tcnt <= '0;
        else if (state inside {ST_PWRT, ST_BPWRT, ST_PLL, ST_WPLL})
            tcnt <= tcnt + 1'b1;
    end

    // Outputs
    always_comb begin
        dev_rst  = !mclr_s;
        clk_hold = 1'b0;
        unique case (state)
            ST_RUN:           ;
            ST_WOST, ST_WPLL: clk_hold = 1'b1;
            default:          dev_rst  = 1'b1;
        endcase
    end

    // Sticky cause flags; a set in the same cycle wins over the clear
    always_ff @(posedge tmr_clk or posedge por_pulse) begin
        if (por_pulse) begin
            flag_por <= 1'b1;
            flag_bor <= 1'b0;
            flag_ext <= 1'b0;
        end else begin
            if (flag_clr) begin
                flag_por <= 1'b0;
                flag_bor <= 1'b0;
                flag_ext <= 1'b0;
            end
            if (nxt == ST_BOR && state != ST_BOR) flag_bor <= 1'b1;
            if (!mclr_s)                          flag_ext <= 1'b1;
        end
    end
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk
    import rst_seq_pkg::*;
(
    input logic       tmr_clk,
    input logic       por_pulse,
    input seq_state_e state,
    input logic       mclr_s,
    input logic       uv_s,
    input logic       dev_rst,
    input logic       clk_hold,
    input logic       flag_bor,
    input logic       flag_ext,
    input logic       flag_clr,
    input logic       cfg_bor_en,
    input logic [1:0] osc_mode
);
    // R8
    pin_forces_rst_chk: assert property (@(posedge tmr_clk) disable iff (por_pulse)
        !mclr_s |-> dev_rst);

    // R5
    no_trip_without_uv_chk: assert property (@(posedge tmr_clk) disable iff (por_pulse)
        (!uv_s && state != ST_BOR) |=> state != ST_BOR);

    // R6
    bor_hold_chk: assert property (@(posedge tmr_clk) disable iff (por_pulse)
        (state == ST_BOR && uv_s) |=> state == ST_BOR);

    // R7
    bor_rearm_chk: assert property (@(posedge tmr_clk) disable iff (por_pulse)
        (state == ST_BPWRT && uv_s && cfg_bor_en) |=> state == ST_BOR);

    // R10
    bor_flag_sticky_chk: assert property (@(posedge tmr_clk) disable iff (por_pulse)
        (flag_bor && !flag_clr) |=> flag_bor);

    // R10
    ext_flag_clear_chk: assert property (@(posedge tmr_clk) disable iff (por_pulse)
        (flag_clr && mclr_s) |=> !flag_ext);

    // R9
    wake_crystal_only_chk: assert property (@(posedge tmr_clk) disable iff (por_pulse)
        $rose(clk_hold) |-> $past(osc_mode) != 2'd3);
endmodule

bind rst_seq_top rst_seq_chk u_chk (
    .tmr_clk(tmr_clk), .por_pulse(por_pulse), .state(state), .mclr_s(mclr_s),
    .uv_s(uv_s), .dev_rst(dev_rst), .clk_hold(clk_hold), .flag_bor(flag_bor),
    .flag_ext(flag_ext), .flag_clr(flag_clr), .cfg_bor_en(cfg_bor_en),
    .osc_mode(osc_mode)
);

// File: tb/sim_rst_seq_top.sv
`timescale 1ns/1ps
module sim_rst_seq_top;
    localparam int P     = 40;
    localparam int L     = 30;
    localparam int F     = 6;
    localparam int OSTC  = 1024;
    localparam int OST_T = (OSTC * 6) / 4;   // settling count in timer edges

    logic tmr_clk = 1'b0, osc_clk = 1'b0;
    logic por_pulse = 1'b1, uv_in = 1'b0, mclr_n = 1'b1;
    logic cfg_pwrt_en = 1'b1, cfg_bor_en = 1'b1, cfg_pll_en = 1'b0;
    logic [1:0] osc_mode = 2'd3;
    logic wake_req = 1'b0, flag_clr = 1'b0;
    logic dev_rst, clk_hold, flag_por, flag_bor, flag_ext;

    int checks = 0, fails = 0, cyc = 0;

    always #2 tmr_clk = ~tmr_clk;
    always #3 osc_clk = ~osc_clk;
    always @(posedge tmr_clk) cyc++;

    rst_seq_top #(.PWRT_CYCLES(P), .PLL_CYCLES(L), .OST_CYCLES(OSTC), .BOR_FILT(F)) u0 (
        .tmr_clk(tmr_clk), .osc_clk(osc_clk), .por_pulse(por_pulse), .uv_in(uv_in),
        .mclr_n(mclr_n), .cfg_pwrt_en(cfg_pwrt_en), .cfg_bor_en(cfg_bor_en),
        .cfg_pll_en(cfg_pll_en), .osc_mode(osc_mode), .wake_req(wake_req),
        .flag_clr(flag_clr), .dev_rst(dev_rst), .clk_hold(clk_hold),
        .flag_por(flag_por), .flag_bor(flag_bor), .flag_ext(flag_ext)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge tmr_clk);
    endtask

    function automatic int exp_release(input bit pw, input bit pll, input logic [1:0] m);
        int n = 1;
        if (pw) n += P;
        if (m != 2'd3) begin
            n += OST_T;
            if (pll) n += L;
        end
        return n;
    endfunction

    task automatic power_on(input bit pw, input bit pll, input logic [1:0] m);
        @(negedge tmr_clk);
        cfg_pwrt_en = pw; cfg_pll_en = pll; osc_mode = m;
        por_pulse = 1'b1;
        tick(4);
        por_pulse = 1'b0;
    endtask

    task automatic measure_rst(output int n);
        n = 0;
        do begin
            @(posedge tmr_clk); n++;
            @(negedge tmr_clk);
        end while (dev_rst && n < 6000);
    endtask

    task automatic release_case(input bit pw, input bit pll, input logic [1:0] m, input string req);
        int n, e, hi;
        power_on(pw, pll, m);
        measure_rst(n);
        e  = exp_release(pw, pll, m);
        hi = (m != 2'd3) ? e + 14 : e + 1;
        chk(n >= e && n <= hi, req, n, e);
    endtask

    // Watchdog
    initial begin
        wait (cyc >= 150000);
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n, seed_dummy;
        bit saw;
        seed_dummy = $urandom(32'h5eed1);

        // R1: reset state
        tick(3);
        chk(dev_rst == 1'b1 && clk_hold == 1'b0, "R1 reset outputs", {dev_rst, clk_hold}, 2);
        chk(flag_por && !flag_bor && !flag_ext, "R1 reset flags", {flag_por, flag_bor, flag_ext}, 4);

        // R2: power-up delay present and skipped
        release_case(1'b0, 1'b0, 2'd3, "R2 RC no delay");
        release_case(1'b1, 1'b0, 2'd3, "R2 RC with delay");
        // R3: settling count in crystal modes
        release_case(1'b1, 1'b0, 2'd1, "R3 XT with delay");
        release_case(1'b0, 1'b0, 2'd0, "R3 LP no delay");
        // R4: PLL wait
        release_case(1'b1, 1'b1, 2'd2, "R4 HS delay+pll");
        release_case(1'b0, 1'b1, 2'd0, "R4 LP pll");
        release_case(1'b1, 1'b1, 2'd3, "R4 RC pll ignored");

        // R8: pin held low past the waits
        mclr_n = 1'b0;
        power_on(1'b1, 1'b0, 2'd3);
        saw = 1'b0;
        repeat (P + 40) begin @(negedge tmr_clk); if (!dev_rst) saw = 1'b1; end
        chk(!saw, "R8 reset held by pin", saw, 0);
        mclr_n = 1'b1;
        measure_rst(n);
        chk(n >= 1 && n <= 3, "R8 release after pin", n, 2);
        chk(flag_ext && flag_por, "R10 ext flag set", {flag_ext, flag_por}, 3);

        // R8: short pin pulse does not restart the delay
        power_on(1'b1, 1'b0, 2'd3);
        tick(10); mclr_n = 1'b0; tick(3); mclr_n = 1'b1;
        measure_rst(n);
        n += 13;
        chk(n >= P + 1 && n <= P + 2, "R8 no restart", n, P + 1);

        // R10: clear strobe
        @(negedge tmr_clk); flag_clr = 1'b1; @(negedge tmr_clk); flag_clr = 1'b0;
        tick(3);
        chk(!flag_por && !flag_bor && !flag_ext, "R10 clear", {flag_por, flag_bor, flag_ext}, 0);

        // R5: dips below the filter window are ignored (directed plus random)
        cfg_bor_en = 1'b1;
        for (int k = 0; k < 6; k++) begin
            int len;
            len = (k == 0) ? F - 1 : 1 + int'($urandom % (F - 1));
            saw = 1'b0;
            uv_in = 1'b1;
            repeat (len) begin @(negedge tmr_clk); if (dev_rst) saw = 1'b1; end
            uv_in = 1'b0;
            repeat (6) begin @(negedge tmr_clk); if (dev_rst) saw = 1'b1; end
            chk(!saw && !flag_bor, "R5 short dip ignored", {saw, flag_bor}, 0);
        end

        // R5: long dip with detection disabled
        cfg_bor_en = 1'b0;
        saw = 1'b0;
        uv_in = 1'b1;
        repeat (F + 10) begin @(negedge tmr_clk); if (dev_rst) saw = 1'b1; end
        uv_in = 1'b0; tick(4);
        chk(!saw && !flag_bor, "R5 disabled no trip", {saw, flag_bor}, 0);
        cfg_bor_en = 1'b1;

        // R5/R6: long dip trips and holds
        uv_in = 1'b1; tick(F + 4);
        chk(dev_rst && flag_bor, "R5 long dip trips", {dev_rst, flag_bor}, 3);
        saw = 1'b0;
        repeat (20) begin @(negedge tmr_clk); if (!dev_rst) saw = 1'b1; end
        chk(!saw, "R6 held during undervoltage", saw, 0);
        uv_in = 1'b0;
        measure_rst(n);
        chk(n >= P + 1 && n <= P + 5, "R6 release after delay", n, P + 3);

        // R7: undervoltage returns during the post-brown-out delay
        uv_in = 1'b1; tick(F + 14); uv_in = 1'b0;
        tick(P / 2);
        chk(dev_rst == 1'b1, "R7 still in delay", dev_rst, 1);
        uv_in = 1'b1; tick(2); uv_in = 1'b0;
        measure_rst(n);
        chk(n >= P + 1 && n <= P + 5, "R7 delay restarted", n, P + 3);

        // R9: wake in XT mode, no PLL
        release_case(1'b0, 1'b0, 2'd1, "R3 XT before wake");
        tick(10);
        wake_req = 1'b1; tick(1); wake_req = 1'b0;
        chk(clk_hold == 1'b1, "R9 clock hold raised", clk_hold, 1);
        n = 0; saw = 1'b0;
        while (clk_hold && n < 6000) begin
            @(negedge tmr_clk); n++;
            if (dev_rst) saw = 1'b1;
        end
        chk(!saw, "R9 device reset stays low", saw, 0);
        chk(n >= OST_T - 4 && n <= OST_T + 14, "R9 wake duration", n, OST_T);

        // R9: wake in HS mode with PLL
        release_case(1'b0, 1'b1, 2'd2, "R4 HS before wake");
        tick(10);
        wake_req = 1'b1; tick(1); wake_req = 1'b0;
        n = 0;
        while (clk_hold && n < 6000) begin @(negedge tmr_clk); n++; end
        chk(n >= OST_T + L - 4 && n <= OST_T + L + 14, "R9 wake with pll", n, OST_T + L);

        // R9: wake ignored in RC mode
        release_case(1'b0, 1'b0, 2'd3, "R2 RC before wake");
        tick(5);
        wake_req = 1'b1; tick(1); wake_req = 1'b0;
        saw = 1'b0;
        repeat (10) begin @(negedge tmr_clk); if (clk_hold || dev_rst) saw = 1'b1; end
        chk(!saw, "R9 RC wake ignored", saw, 0);

        // Random configurations (R2, R3, R4)
        for (int k = 0; k < 8; k++) begin
            bit pw, pll;
            logic [1:0] m;
            pw  = 1'($urandom % 2);
            pll = 1'($urandom % 2);
            m   = 2'($urandom % 4);
            release_case(pw, pll, m, "R2 R3 R4 random config");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule